// File: doc/BRIEF.md
# UART interrupt identification logic

This block decides which interrupt source of a 16550-style serial port is reported to the host, and drives the single level interrupt request. It owns the 4-bit interrupt-enable register, the transmit-empty pending flag, and the sticky overrun and break flags. The receiver, the transmitter, the FIFO storage and the modem-line sampler sit outside. They supply data-ready, parity and framing status, the character-timeout pending flag, the receive count and trigger level, the FIFO-enable flag, a holding-register-empty level and the modem delta bits.

Each cycle a priority chain picks one source. The result is stored in a state register, `cur_src`, which takes one of the values SRC_NONE, SRC_LINE, SRC_TMO, SRC_RXD, SRC_THR or SRC_MDM. There is no sequencing between these states. Every cycle the register is reloaded with the winner of the chain, so each state can go straight to any other, SRC_NONE included, whenever the flags change. The identification byte and the request line are decoded from this register. A status flag that changes at a clock edge therefore shows up in `iir` and `irq` one cycle later.

Register reads and writes arrive as one-cycle strobes. An identification read returns `iir` as sampled in the strobe cycle. If that value reports the transmit-empty source, the read clears the transmit pending flag. An enable write stores the enable bits and re-arms the transmit pending flag while the holding register is empty. A line-status read clears the sticky overrun and break flags.

Top module: `idf_uart_irq_id`

## Requirements
- R1: After reset `iir` is 0x01, `irq` is 0, `ier_q` is 0 and `line_err` is 0.
- R2: Sources are ranked from highest to lowest as line status (ID 0x6), character timeout (ID 0xC), receive data (ID 0x4), transmit empty (ID 0x2) and modem status (ID 0x0). With nothing pending the low nibble of `iir` is 0x1.
- R3: The line-status source is pending when enable bit 2 is set and any bit of `line_err` is set. The layout is `line_err` = {break, framing, parity, overrun}.
- R4: The character-timeout source needs both `tmo_pend` and enable bit 0. Enable bit 0 is the receive-data enable, so clearing that bit masks the timeout as well.
- R5: The receive-data source needs enable bit 0, `rx_ready`, and one further condition: `fifo_en` is low, or `rx_count` is greater than or equal to `rx_trig`.
- R6: The transmit-empty source needs enable bit 1 and the pending flag. The flag is set when `thr_empty` rises and is cleared by `wr_thr`.
- R7: The modem-status source needs enable bit 3 and any bit of `mdm_delta`.
- R8: Bits 7:6 of `iir` are 11 when `fifo_en` was high in the previous cycle and 00 otherwise. Bits 5:4 are 0.
- R9: A `rd_iir` strobe returns the `iir` of its own cycle. If that value has ID 0x2, the strobe clears the transmit pending flag.
- R10: `wr_ier` stores `wr_data[3:0]` into `ier_q`. It also sets the transmit pending flag when `thr_empty` is high.
- R11: `rd_lsr` clears the overrun and break flags. The parity and framing bits of `line_err` always follow `par_err` and `frm_err`.
- R12: `irq` is a registered output. It is high exactly when the low nibble of `iir` is not 0x1. A status change at a clock edge reaches `iir` and `irq` one cycle later.
- R13: When a set and a clear of the same flag occur in the same cycle, the set wins. This holds for the overrun, break and transmit pending flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ier | input | 1 | Enable-register write strobe |
| wr_data | input | 8 | Write data for the enable register |
| rd_iir | input | 1 | Identification read strobe |
| rd_lsr | input | 1 | Line-status read strobe |
| wr_thr | input | 1 | Holding-register write strobe |
| fifo_en | input | 1 | FIFOs enabled |
| rx_ready | input | 1 | Receive data ready |
| rx_count | input | 5 | Receive FIFO fill count |
| rx_trig | input | 5 | Receive trigger level |
| tmo_pend | input | 1 | Character-timeout pending |
| par_err | input | 1 | Parity error status |
| frm_err | input | 1 | Framing error status |
| ovr_set | input | 1 | Overrun event pulse |
| brk_set | input | 1 | Break event pulse |
| thr_empty | input | 1 | Holding register empty level |
| mdm_delta | input | 4 | Modem-status delta bits |
| ier_q | output | 4 | Stored interrupt enables |
| iir | output | 8 | Interrupt identification value |
| line_err | output | 4 | {break, framing, parity, overrun} |
| irq | output | 1 | Level interrupt request |

## Verification
Several properties are checked on every cycle by the bound assertions. They cover the enable-register store, the FIFO marker bits, and the line source beating everything else whenever it is enabled and active. They also check that both receive-side IDs vanish while enable bit 0 is clear, that the request line stays low while all enables were zero, and that the transmit flag is cleared by an identification read and the error flags by a line-status read. The full five-level ranking, the trigger-level boundary in FIFO mode, the re-arming of the transmit flag by an enable write, the pre-clear value returned by a read, and set-over-clear collisions are shown only by the bench's directed scenarios.

// File: rtl/idf_pkg.sv
package idf_pkg;

    // Interrupt source selected by the arbiter, one per state.
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_LINE = 3'd1,
        SRC_TMO  = 3'd2,
        SRC_RXD  = 3'd3,
        SRC_THR  = 3'd4,
        SRC_MDM  = 3'd5
    } src_e;

    // Identification codes in the low nibble of the IIR.
    localparam logic [3:0] ID_NONE = 4'h1;
    localparam logic [3:0] ID_LINE = 4'h6;
    localparam logic [3:0] ID_TMO  = 4'hC;
    localparam logic [3:0] ID_RXD  = 4'h4;
    localparam logic [3:0] ID_THR  = 4'h2;
    localparam logic [3:0] ID_MDM  = 4'h0;

    // Bit positions in the enable register.
    localparam int EN_RXD  = 0;
    localparam int EN_THR  = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;

    // Width of the enable register and of the error vector.
    localparam int IER_W  = 4;
    localparam int LERR_W = 4;

    // Positions inside line_err = {break, framing, parity, overrun}.
    localparam int LE_OVR = 0;
    localparam int LE_PAR = 1;
    localparam int LE_FRM = 2;
    localparam int LE_BRK = 3;

    function automatic logic [3:0] src_to_id(input src_e s);
        logic [3:0] r;
        unique case (s)
            SRC_LINE: r = ID_LINE;
            SRC_TMO:  r = ID_TMO;
            SRC_RXD:  r = ID_RXD;
            SRC_THR:  r = ID_THR;
            SRC_MDM:  r = ID_MDM;
            default:  r = ID_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/idf_enable_reg.sv
module idf_enable_reg
    import idf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ier,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_thr,
    input  logic              rd_iir,
    input  logic              iir_is_thr,
    input  logic              thr_empty,
    output logic [IER_W-1:0]  ier_q,
    output logic              thr_pend
);

    logic thre_q;
    logic pend_set;
    logic pend_clr;
    logic pend_d;

    // Set events: holding register just became empty, or an enable write
    // while it is empty. Clear events: a new character or an
    // acknowledging identification read.
    always_comb begin
        pend_set = (thr_empty && !thre_q) || (wr_ier && thr_empty);
        pend_clr = wr_thr || (rd_iir && iir_is_thr);
        if (pend_set) begin
            pend_d = 1'b1;
        end else if (pend_clr) begin
            pend_d = 1'b0;
        end else begin
            pend_d = thr_pend;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ier_q    <= '0;
            thre_q   <= 1'b0;
            thr_pend <= 1'b0;
        end else begin
            thre_q   <= thr_empty;
            thr_pend <= pend_d;
            if (wr_ier) begin
                ier_q <= wr_data[IER_W-1:0];
            end
        end
    end

endmodule

// File: rtl/idf_line_flags.sv
module idf_line_flags
    import idf_pkg::*;
#(
    parameter int STICKY_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovr_set,
    input  logic              brk_set,
    input  logic              par_err,
    input  logic              frm_err,
    input  logic              rd_lsr,
    output logic [LERR_W-1:0] line_err
);

    logic [STICKY_N-1:0] set_v;
    logic [STICKY_N-1:0] flag_q;

    // Index 0 is overrun and index 1 is break.
    assign set_v = {brk_set, ovr_set};

    for (genvar g = 0; g < STICKY_N; g++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else if (set_v[g]) begin
                flag_q[g] <= 1'b1;
            end else if (rd_lsr) begin
                flag_q[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        line_err         = '0;
        line_err[LE_OVR] = flag_q[0];
        line_err[LE_BRK] = flag_q[1];
        line_err[LE_PAR] = par_err;
        line_err[LE_FRM] = frm_err;
    end

endmodule

// File: rtl/idf_arbiter.sv
module idf_arbiter
    import idf_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int MDM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IER_W-1:0]  ier,
    input  logic [LERR_W-1:0] line_err,
    input  logic              tmo_pend,
    input  logic              rx_ready,
    input  logic              fifo_en,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic              thr_pend,
    input  logic [MDM_W-1:0]  mdm_delta,
    output logic [7:0]        iir,
    output logic              irq,
    output logic              iir_is_thr
);

    src_e cur_src;
    src_e nxt_src;
    logic fifo_q;
    logic irq_q;
    logic rx_level_ok;
    logic [3:0] id;

    assign rx_level_ok = !fifo_en || (rx_count >= rx_trig);

    // Priority chain: every cycle the highest active source wins.
    always_comb begin
        if (ier[EN_LINE] && (|line_err)) begin
            nxt_src = SRC_LINE;
        end else if (ier[EN_RXD] && tmo_pend) begin
            nxt_src = SRC_TMO;
        end else if (ier[EN_RXD] && rx_ready && rx_level_ok) begin
            nxt_src = SRC_RXD;
        end else if (ier[EN_THR] && thr_pend) begin
            nxt_src = SRC_THR;
        end else if (ier[EN_MDM] && (|mdm_delta)) begin
            nxt_src = SRC_MDM;
        end else begin
            nxt_src = SRC_NONE;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_src <= SRC_NONE;
            fifo_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            cur_src <= nxt_src;
            fifo_q  <= fifo_en;
            irq_q   <= (nxt_src != SRC_NONE);
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        id         = src_to_id(cur_src);
        iir_is_thr = 1'b0;
        unique case (cur_src)
            SRC_THR:  iir_is_thr = 1'b1;
            SRC_NONE, SRC_LINE, SRC_TMO, SRC_RXD, SRC_MDM: iir_is_thr = 1'b0;
            default:  iir_is_thr = 1'b0;
        endcase
        iir = {fifo_q, fifo_q, 2'b00, id};
        irq = irq_q;
    end

endmodule

// File: rtl/idf_uart_irq_id.sv
module idf_uart_irq_id
    import idf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16,
    parameter int MDM_W      = 4,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ier,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_iir,
    input  logic              rd_lsr,
    input  logic              wr_thr,
    input  logic              fifo_en,
    input  logic              rx_ready,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  rx_trig,
    input  logic              tmo_pend,
    input  logic              par_err,
    input  logic              frm_err,
    input  logic              ovr_set,
    input  logic              brk_set,
    input  logic              thr_empty,
    input  logic [MDM_W-1:0]  mdm_delta,
    output logic [IER_W-1:0]  ier_q,
    output logic [7:0]        iir,
    output logic [LERR_W-1:0] line_err,
    output logic              irq
);

    logic thr_pend;
    logic iir_is_thr;

    idf_enable_reg #(.DATA_W(DATA_W)) u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ier     (wr_ier),
        .wr_data    (wr_data),
        .wr_thr     (wr_thr),
        .rd_iir     (rd_iir),
        .iir_is_thr (iir_is_thr),
        .thr_empty  (thr_empty),
        .ier_q      (ier_q),
        .thr_pend   (thr_pend)
    );

    idf_line_flags #(.STICKY_N(2)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr_set  (ovr_set),
        .brk_set  (brk_set),
        .par_err  (par_err),
        .frm_err  (frm_err),
        .rd_lsr   (rd_lsr),
        .line_err (line_err)
    );

    idf_arbiter #(.CNT_W(CNT_W), .MDM_W(MDM_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ier        (ier_q),
        .line_err   (line_err),
        .tmo_pend   (tmo_pend),
        .rx_ready   (rx_ready),
        .fifo_en    (fifo_en),
        .rx_count   (rx_count),
        .rx_trig    (rx_trig),
        .thr_pend   (thr_pend),
        .mdm_delta  (mdm_delta),
        .iir        (iir),
        .irq        (irq),
        .iir_is_thr (iir_is_thr)
    );

endmodule

// File: rtl/idf_uart_irq_id_chk.sv
module idf_uart_irq_id_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_ier,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_iir,
    input logic              rd_lsr,
    input logic              ovr_set,
    input logic              brk_set,
    input logic              fifo_en,
    input logic              thr_empty,
    input logic [3:0]        ier_q,
    input logic [7:0]        iir,
    input logic [3:0]        line_err,
    input logic              irq,
    input logic              thr_pend
);

    AST_IER_LOW_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ier |=> (ier_q == $past(wr_data[3:0]))); // R10

    AST_FIFO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (iir[7:6] == {2{$past(fifo_en)}}) && (iir[5:4] == 2'b00)); // R8

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ier_q[2] && (|line_err))) |-> (iir[3:0] == 4'h6)); // R2

    AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ier_q[0])) |-> (iir[3:0] != 4'hC) && (iir[3:0] != 4'h4)); // R4

    AST_NO_IRQ_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(ier_q) == 4'h0)) |-> !irq); // R12

    AST_THR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iir && (iir[3:0] == 4'h2) && !wr_ier && !$rose(thr_empty)) |=> !thr_pend); // R9

    AST_LSR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !ovr_set && !brk_set) |=> (!line_err[0] && !line_err[3])); // R11

endmodule

bind idf_uart_irq_id idf_uart_irq_id_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ier    (wr_ier),
    .wr_data   (wr_data),
    .rd_iir    (rd_iir),
    .rd_lsr    (rd_lsr),
    .ovr_set   (ovr_set),
    .brk_set   (brk_set),
    .fifo_en   (fifo_en),
    .thr_empty (thr_empty),
    .ier_q     (ier_q),
    .iir       (iir),
    .line_err  (line_err),
    .irq       (irq),
    .thr_pend  (thr_pend)
);

// File: tb/idf_uart_irq_id_test.sv
`timescale 1ns/1ps
module idf_uart_irq_id_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_ier, rd_iir, rd_lsr, wr_thr;
    logic [7:0] wr_data;
    logic       fifo_en, rx_ready, tmo_pend, par_err, frm_err;
    logic       ovr_set, brk_set, thr_empty;
    logic [4:0] rx_count, rx_trig;
    logic [3:0] mdm_delta;
    logic [3:0] ier_q;
    logic [7:0] iir;
    logic [3:0] line_err;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    idf_uart_irq_id uut (
        .clk(clk), .rst_n(rst_n), .wr_ier(wr_ier), .wr_data(wr_data),
        .rd_iir(rd_iir), .rd_lsr(rd_lsr), .wr_thr(wr_thr),
        .fifo_en(fifo_en), .rx_ready(rx_ready), .rx_count(rx_count),
        .rx_trig(rx_trig), .tmo_pend(tmo_pend), .par_err(par_err),
        .frm_err(frm_err), .ovr_set(ovr_set), .brk_set(brk_set),
        .thr_empty(thr_empty), .mdm_delta(mdm_delta), .ier_q(ier_q),
        .iir(iir), .line_err(line_err), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Two negedges: enough for a registered flag and then the state.
    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic write_ier(input logic [7:0] v);
        wr_data = v; wr_ier = 1'b1;
        @(negedge clk);
        wr_ier = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_lsr_read();
        rd_lsr = 1'b1;
        @(negedge clk);
        rd_lsr = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 iir", iir, 8'h01);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 ier", {4'd0, ier_q}, 8'h00);
        chk("R1 line_err", {4'd0, line_err}, 8'h00);
    endtask

    task automatic t_ier_store();
        write_ier(8'hF7);
        chk("R10 low nibble", {4'd0, ier_q}, 8'h07);
        settle();
        chk("R12 idle iir", iir, 8'h01);
        write_ier(8'h00);
    endtask

    task automatic t_line();
        write_ier(8'h04);
        ovr_set = 1'b1; @(negedge clk); ovr_set = 1'b0; @(negedge clk);
        chk("R3 overrun flag", {4'd0, line_err}, 8'h01);
        chk("R3 overrun id", iir, 8'h06);
        chk("R12 irq on", {7'd0, irq}, 8'h01);
        pulse_lsr_read();
        chk("R11 overrun cleared", {4'd0, line_err}, 8'h00);
        chk("R11 id after clear", iir, 8'h01);
        par_err = 1'b1;
        settle();
        chk("R3 parity id", iir, 8'h06);
        pulse_lsr_read();
        chk("R11 parity follows input", {4'd0, line_err}, 8'h02);
        par_err = 1'b0;
        settle();
        chk("R12 irq off", {7'd0, irq}, 8'h00);
        write_ier(8'h00);
        brk_set = 1'b1; @(negedge clk); brk_set = 1'b0; @(negedge clk);
        chk("R3 break flag", {4'd0, line_err}, 8'h08);
        chk("R3 masked break", iir, 8'h01);
        pulse_lsr_read();
        chk("R11 break cleared", {4'd0, line_err}, 8'h00);
    endtask

    task automatic t_set_wins();
        ovr_set = 1'b1; rd_lsr = 1'b1;
        @(negedge clk);
        ovr_set = 1'b0; rd_lsr = 1'b0;
        @(negedge clk);
        chk("R13 set beats clear", {4'd0, line_err}, 8'h01);
        pulse_lsr_read();
    endtask

    task automatic t_rxd();
        write_ier(8'h01);
        rx_ready = 1'b1;
        settle();
        chk("R5 no fifo data", iir, 8'h04);
        fifo_en = 1'b1; rx_count = 5'd3; rx_trig = 5'd4;
        settle();
        chk("R5 below trigger", iir, 8'hC1);
        chk("R8 fifo mark", {6'd0, iir[7:6]}, 8'h03);
        rx_count = 5'd4;
        settle();
        chk("R5 at trigger", iir, 8'hC4);
        rx_count = 5'd5;
        settle();
        chk("R5 above trigger", iir, 8'hC4);
        fifo_en = 1'b0; rx_ready = 1'b0; rx_count = 5'd0;
        settle();
        chk("R8 fifo mark off", iir, 8'h01);
    endtask

    task automatic t_tmo();
        tmo_pend = 1'b1;
        settle();
        chk("R4 timeout id", iir, 8'h0C);
        write_ier(8'h0E);
        settle();
        chk("R4 timeout masked", iir, 8'h01);
        tmo_pend = 1'b0;
        write_ier(8'h00);
    endtask

    task automatic t_thr();
        write_ier(8'h02);
        thr_empty = 1'b1;
        settle();
        chk("R6 empty rise", iir, 8'h02);
        rd_iir = 1'b1;
        chk("R9 read value pre-clear", iir, 8'h02);
        @(negedge clk);
        rd_iir = 1'b0;
        @(negedge clk);
        chk("R9 read clears pending", iir, 8'h01);
        write_ier(8'h02);
        settle();
        chk("R10 write re-arms", iir, 8'h02);
        wr_thr = 1'b1; @(negedge clk); wr_thr = 1'b0;
        thr_empty = 1'b0;
        settle();
        chk("R6 thr write clears", iir, 8'h01);
        write_ier(8'h00);
    endtask

    task automatic t_mdm();
        write_ier(8'h08);
        mdm_delta = 4'b0100;
        settle();
        chk("R7 modem id", iir, 8'h00);
        chk("R12 irq with id 0", {7'd0, irq}, 8'h01);
        mdm_delta = 4'b0000;
        settle();
        chk("R7 modem gone", iir, 8'h01);
        write_ier(8'h00);
    endtask

    task automatic t_priority();
        write_ier(8'h0F);
        ovr_set = 1'b1; tmo_pend = 1'b1; rx_ready = 1'b1;
        mdm_delta = 4'b0001; thr_empty = 1'b1;
        @(negedge clk);
        ovr_set = 1'b0;
        settle();
        chk("R2 line first", iir, 8'h06);
        pulse_lsr_read();
        settle();
        chk("R2 timeout second", iir, 8'h0C);
        tmo_pend = 1'b0;
        settle();
        chk("R2 data third", iir, 8'h04);
        rx_ready = 1'b0;
        settle();
        chk("R2 thr fourth", iir, 8'h02);
        rd_iir = 1'b1; @(negedge clk); rd_iir = 1'b0; @(negedge clk);
        chk("R2 modem last", iir, 8'h00);
        mdm_delta = 4'b0000;
        settle();
        chk("R2 none", iir, 8'h01);
        thr_empty = 1'b0;
        write_ier(8'h00);
    endtask

    initial begin
        rst_n = 1'b0; wr_ier = 1'b0; rd_iir = 1'b0; rd_lsr = 1'b0;
        wr_thr = 1'b0; wr_data = 8'h00; fifo_en = 1'b0; rx_ready = 1'b0;
        tmo_pend = 1'b0; par_err = 1'b0; frm_err = 1'b0; ovr_set = 1'b0;
        brk_set = 1'b0; thr_empty = 1'b0; rx_count = 5'd0; rx_trig = 5'd1;
        mdm_delta = 4'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ier_store();
        t_line();
        t_set_wins();
        t_rxd();
        t_tmo();
        t_thr();
        t_mdm();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule